// File: doc/BRIEF.md
# Paged SPI Byte Bridge

This block lets a host that only has a narrow byte-wide I/O window drive an SPI flash master port. The window has five byte registers. Offsets 0 to 3 hold a 32-bit pointer in little-endian byte order. Offset 4 is a data port. Writing the pointer bytes has no side effect. An access to the data port is steered by address byte 1 (pointer bits 15:8):

- Page 0xFE releases chip select.
- Page 0xFD keeps chip select asserted and moves exactly one byte across the serial link in SPI mode 0, most significant bit first.
- Any other page leaves the serial side untouched.

A flash command is issued as a chip-select release, then the opcode, address and data bytes as data-port writes, then the reply bytes as data-port reads, then a final release. Software normally presets the other pointer bytes to 0x00, 0xFF and 0xFF, and keeps each transaction within 64 written and 64 read bytes. The bridge itself does not limit the count.

The controller has two states.

- `ST_IDLE` accepts host requests. The transition `IDLE->SHIFT` is taken on a data-port access with page 0xFD.
- `ST_SHIFT` holds the host off with `host_wait` while the byte shifter runs. The transition `SHIFT->IDLE` is taken on the cycle the shifter reports its final falling SCK edge; on a read, the received byte is latched into `host_rdata` in that same cycle.

All other accepted requests stay in `ST_IDLE` and complete in one cycle.

Top module: `spi_window_bridge`

## Requirements
- R1: A host write to offsets 0 to 3 stores the byte as pointer byte 0 to 3, with offset 1 being pointer bits 15:8. A read of the same offset returns the stored byte one cycle after the request, without asserting `host_wait`.
- R2: A data-port (offset 4) write while pointer byte 1 is 0xFE drives `spi_csn` high on the next cycle, whatever the written value, and produces no SCK edge.
- R3: A data-port write while pointer byte 1 is 0xFD drives `spi_csn` low and shifts the written byte out on `spi_mosi`, most significant bit first. SCK idles low, MOSI is stable while SCK is high, and the slave samples on rising edges.
- R4: A data-port read while pointer byte 1 is 0xFD keeps `spi_csn` low, shifts out 0x00, and returns in `host_rdata` the 8 bits sampled from `spi_miso` on the rising SCK edges, first bit as bit 7.
- R5: After a 0xFD-page data-port access, `host_wait` is high from the next cycle for exactly 16*SCK_HALF cycles. `host_rdata` holds the read result in the first cycle `host_wait` is low.
- R6: A data-port access with any other value of pointer byte 1, or any access to offsets 5 to 7, leaves `spi_csn` unchanged, produces no SCK edge and no wait, and reads as 0xFF.
- R7: After reset, `spi_csn` is 1, `spi_sck` is 0, `host_wait` is 0, `host_rdata` is 0x00 and all pointer bytes are 0x00. SCK only toggles while `spi_csn` is low.
- R8: Requests presented while `host_wait` is high are ignored, including pointer writes.
- R9: A full transaction (release, write bytes, read bytes, release) presents the write bytes to the slave in order and returns the slave's reply bytes in order, ending with `spi_csn` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | One-cycle host access strobe, accepted when host_wait is low |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 3 | Window offset: 0-3 pointer bytes, 4 data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_wait | output | 1 | High while a serial byte is in flight |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_csn | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
If the controller leaves `ST_SHIFT` early or late, the error shows at once as a `host_wait` pulse whose length differs from 16*SCK_HALF cycles. A shift register that slips by one position shows on the first transferred byte, as a wrong byte at the slave model or in `host_rdata`. A page decode that looks at the wrong pointer byte shows within one cycle of a data-port access, as an unexpected chip-select change or a wait pulse where none is due. Pointer registers that are corrupted while busy show on the next read-back of the window.

// File: rtl/spi_window_pkg.sv
package spi_window_pkg;
    localparam int unsigned PTR_BYTES = 4;
    localparam logic [2:0]  DATA_OFF  = 3'd4;
    localparam logic [7:0]  PAGE_RELEASE = 8'hFE;
    localparam logic [7:0]  PAGE_XFER    = 8'hFD;
    localparam logic [7:0]  RD_EMPTY  = 8'hFF;
    localparam logic [7:0]  TX_FILL   = 8'h00;

    typedef enum logic [1:0] {
        PG_NONE    = 2'd0,
        PG_RELEASE = 2'd1,
        PG_XFER    = 2'd2
    } page_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } ctrl_state_e;

    function automatic page_e classify_page(input logic [7:0] sel_byte);
        if (sel_byte == PAGE_RELEASE)   return PG_RELEASE;
        else if (sel_byte == PAGE_XFER) return PG_XFER;
        else                            return PG_NONE;
    endfunction
endpackage

// File: rtl/ptr_window.sv
module ptr_window
    import spi_window_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [2:0]               off,
    input  logic [7:0]               wdata,
    output logic [8*PTR_BYTES-1:0]   ptr,
    output logic [7:0]               rd_byte,
    output page_e                    page
);
    localparam int unsigned PW = 8 * PTR_BYTES;

    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < PTR_BYTES; i++) begin
                if (off == 3'(i)) ptr_q[8*i +: 8] <= wdata;
            end
        end
    end

    always_comb begin
        rd_byte = RD_EMPTY;
        for (int i = 0; i < PTR_BYTES; i++) begin
            if (off == 3'(i)) rd_byte = ptr_q[8*i +: 8];
        end
    end

    assign ptr  = ptr_q;
    assign page = classify_page(ptr_q[15:8]);

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ptr_q));
endmodule

// File: rtl/byte_shifter.sv
module byte_shifter #(
    parameter int unsigned SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int unsigned CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(SCK_HALF - 1);

    logic [CW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    tx_q, rx_q;
    logic          sck_q, busy_q, tick;

    assign tick = busy_q && (div_q == DIV_LAST);
    assign done = tick && sck_q && (bit_q == 3'd7);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            bit_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            sck_q  <= 1'b0;
            busy_q <= 1'b0;
        end else if (start && !busy_q) begin
            div_q  <= '0;
            bit_q  <= '0;
            tx_q   <= tx_byte;
            rx_q   <= '0;
            sck_q  <= 1'b0;
            busy_q <= 1'b1;
        end else if (tick) begin
            div_q <= '0;
            if (!sck_q) begin
                sck_q <= 1'b1;
                rx_q  <= {rx_q[6:0], miso};
            end else begin
                sck_q <= 1'b0;
                if (bit_q == 3'd7) begin
                    busy_q <= 1'b0;
                end else begin
                    tx_q  <= {tx_q[6:0], 1'b0};
                    bit_q <= bit_q + 3'd1;
                end
            end
        end else if (busy_q) begin
            div_q <= div_q + CW'(1);
        end
    end

    assign sck     = sck_q;
    assign mosi    = tx_q[7];
    assign busy    = busy_q;
    assign rx_byte = rx_q;

    assert_sck_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sck_q);
    assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(tx_q[7]));
endmodule

// File: rtl/spi_window_bridge.sv
module spi_window_bridge
    import spi_window_pkg::*;
#(
    parameter int unsigned SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_req,
    input  logic       host_wr,
    input  logic [2:0] host_off,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       host_wait,
    output logic       spi_sck,
    output logic       spi_csn,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    ctrl_state_e state_q, state_d;
    page_e       page;
    logic [8*PTR_BYTES-1:0] ptr;
    logic [7:0]  ptr_rd, rx_byte, rdata_q;
    logic        accept, data_acc, start_shift, sh_done, sh_busy;
    logic        csn_q, rd_pend_q;

    assign accept      = host_req && (state_q == ST_IDLE);
    assign data_acc    = accept && (host_off == DATA_OFF);
    assign start_shift = data_acc && (page == PG_XFER);

    ptr_window u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && host_wr),
        .off     (host_off),
        .wdata   (host_wdata),
        .ptr     (ptr),
        .rd_byte (ptr_rd),
        .page    (page)
    );

    byte_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_shift),
        .tx_byte (host_wr ? host_wdata : TX_FILL),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (rx_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_shift) state_d = ST_SHIFT;
            ST_SHIFT: if (sh_done)     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_q     <= 1'b1;
            rd_pend_q <= 1'b0;
            rdata_q   <= 8'h00;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (data_acc && host_wr && page == PG_RELEASE) csn_q <= 1'b1;
                    if (start_shift) begin
                        csn_q     <= 1'b0;
                        rd_pend_q <= !host_wr;
                    end
                    if (accept && !host_wr && !start_shift) begin
                        rdata_q <= (host_off < DATA_OFF) ? ptr_rd : RD_EMPTY;
                    end
                end
                ST_SHIFT: begin
                    if (sh_done && rd_pend_q) rdata_q <= rx_byte;
                end
            endcase
        end
    end

    assign spi_csn    = csn_q;
    assign host_rdata = rdata_q;
    assign host_wait  = (state_q == ST_SHIFT);

    assert_cs_low_in_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> !spi_csn);
    assert_sck_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> !spi_csn);
    assert_wait_on_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_wait && host_off == 3'd4 && ptr[15:8] == 8'hFD) |=> host_wait);
    assert_release_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_wait && host_wr && host_off == 3'd4 && ptr[15:8] == 8'hFE)
        |=> spi_csn);
    assert_other_page_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_wait && host_off == 3'd4 && ptr[15:8] != 8'hFE && ptr[15:8] != 8'hFD)
        |=> ($stable(spi_csn) && !host_wait));
    assert_shifter_matches_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> host_wait);
endmodule

// File: tb/test_spi_window_bridge.sv
module test_spi_window_bridge;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req = 1'b0, host_wr = 1'b0;
    logic [2:0] host_off = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_wait, spi_sck, spi_csn, spi_mosi, spi_miso;

    int tests_run = 0, tests_fail = 0;
    int sck_rises = 0;

    // slave model
    logic [2:0] s_bit = '0;
    int         s_idx = 0;
    logic [7:0] s_cap = '0;
    logic [7:0] cap_log [256];
    int         cap_n = 0;

    function automatic logic [7:0] reply(input int i);
        return 8'h96 ^ 8'(i * 33);
    endfunction

    always #5 clk = ~clk;

    spi_window_bridge #(.SCK_HALF(HALF)) i_spi_window_bridge (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_wait(host_wait), .spi_sck(spi_sck), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    assign spi_miso = reply(s_idx)[7 - s_bit];

    always @(posedge spi_sck or negedge spi_sck or posedge spi_csn) begin
        if (spi_csn) begin
            s_bit = '0;
            s_idx = 0;
        end else if (spi_sck) begin
            sck_rises++;
            s_cap = {s_cap[6:0], spi_mosi};
        end else begin
            if (s_bit == 3'd7) begin
                cap_log[cap_n[7:0]] = s_cap;
                cap_n++;
                s_idx++;
            end
            s_bit = s_bit + 3'd1;
        end
    end

    task automatic check(input string rq, input int act, input int exp);
        tests_run++;
        if (act !== exp) begin
            tests_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic host_op(input logic [2:0] off, input logic wr, input logic [7:0] wd,
                           output logic [7:0] rd, output int wcyc);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_off = off; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        wcyc = 0;
        while (host_wait && wcyc < 1000) begin
            wcyc++;
            @(negedge clk);
        end
        rd = host_rdata;
    endtask

    task automatic set_page(input logic [7:0] pg);
        logic [7:0] r; int w;
        host_op(3'd1, 1'b1, pg, r, w);
    endtask

    task automatic t_reset;
        logic [7:0] r; int w;
        check("R7 csn", spi_csn, 1);
        check("R7 sck", spi_sck, 0);
        check("R7 wait", host_wait, 0);
        check("R7 rdata", host_rdata, 8'h00);
        host_op(3'd1, 1'b0, 8'h00, r, w);
        check("R7 ptr byte1", r, 8'h00);
        host_op(3'd4, 1'b0, 8'h00, r, w);
        check("R6 read outside pages", r, 8'hFF);
    endtask

    task automatic t_window;
        logic [7:0] r; int w;
        logic [7:0] v [4] = '{8'h00, 8'hFE, 8'hFF, 8'hFF};
        for (int i = 0; i < 4; i++) host_op(3'(i), 1'b1, v[i], r, w);
        for (int i = 0; i < 4; i++) begin
            host_op(3'(i), 1'b0, 8'h00, r, w);
            check("R1 readback", r, v[i]);
            check("R1 no wait", w, 0);
        end
    endtask

    task automatic t_write_shift;
        logic [7:0] r; int w; int n0;
        set_page(8'hFE);
        host_op(3'd4, 1'b1, 8'h00, r, w);
        set_page(8'hFD);
        n0 = cap_n;
        host_op(3'd4, 1'b1, 8'hA6, r, w);
        check("R3 csn low", spi_csn, 0);
        check("R3 byte count", cap_n - n0, 1);
        check("R3 mosi byte", cap_log[n0[7:0]], 8'hA6);
        check("R5 wait length", w, 16 * HALF);
    endtask

    task automatic t_cs_release;
        logic [7:0] r; int w; int e0;
        set_page(8'hFE);
        e0 = sck_rises;
        host_op(3'd4, 1'b1, 8'h5A, r, w);
        check("R2 csn high", spi_csn, 1);
        check("R2 no sck", sck_rises - e0, 0);
        check("R2 no wait", w, 0);
    endtask

    task automatic t_read_shift;
        logic [7:0] r; int w; int n0;
        set_page(8'hFE);
        host_op(3'd4, 1'b1, 8'h00, r, w);
        set_page(8'hFD);
        n0 = cap_n;
        host_op(3'd4, 1'b0, 8'h00, r, w);
        check("R4 read byte", r, reply(0));
        check("R4 mosi fill", cap_log[n0[7:0]], 8'h00);
        check("R4 csn low", spi_csn, 0);
        check("R5 read wait", w, 16 * HALF);
    endtask

    task automatic t_ignore;
        logic [7:0] r; int w; int e0; logic cs0;
        set_page(8'h12);
        e0 = sck_rises; cs0 = spi_csn;
        host_op(3'd4, 1'b1, 8'h77, r, w);
        check("R6 csn unchanged", spi_csn, cs0);
        check("R6 no sck", sck_rises - e0, 0);
        check("R6 no wait", w, 0);
        host_op(3'd4, 1'b0, 8'h00, r, w);
        check("R6 read ff", r, 8'hFF);
        host_op(3'd6, 1'b0, 8'h00, r, w);
        check("R6 offset6 ff", r, 8'hFF);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] r; int w;
        set_page(8'hFD);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_off = 3'd4; host_wdata = 8'h3C;
        @(negedge clk);
        host_off = 3'd1; host_wdata = 8'h12;
        @(negedge clk);
        host_req = 1'b0;
        while (host_wait) @(negedge clk);
        host_op(3'd1, 1'b0, 8'h00, r, w);
        check("R8 ptr unchanged", r, 8'hFD);
        check("R8 csn still low", spi_csn, 0);
    endtask

    task automatic t_transaction;
        logic [7:0] r; int w; int n0;
        logic [7:0] wb [3] = '{8'h03, 8'h12, 8'hC4};
        set_page(8'hFE);
        host_op(3'd4, 1'b1, 8'hFF, r, w);
        set_page(8'hFD);
        n0 = cap_n;
        for (int i = 0; i < 3; i++) host_op(3'd4, 1'b1, wb[i], r, w);
        for (int i = 0; i < 3; i++) check("R9 write order", cap_log[8'(n0 + i)], wb[i]);
        for (int i = 0; i < 2; i++) begin
            host_op(3'd4, 1'b0, 8'h00, r, w);
            check("R9 read order", r, reply(3 + i));
        end
        set_page(8'hFE);
        host_op(3'd4, 1'b1, 8'h00, r, w);
        check("R9 end csn high", spi_csn, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_write_shift();
        t_cs_release();
        t_read_shift();
        t_ignore();
        t_busy_ignore();
        t_transaction();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests_run++;
        tests_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end
endmodule